// File: doc/BRIEF.md
# Telecom Frame-Clock Tracking DPLL

This block derives all internal frame and bit timing of a telecom switching device from a reference clock plus an 8 kHz frame pulse. It runs on a 131.072 MHz system clock. It takes one of six clock/frame reference pairs, which cover two backplane buses, two compatibility sources and two local ports. A select input chooses the pair. The chosen pair passes through two-flop synchronizers and rising-edge detectors. The detected edges steer a free-running timebase.

The loop tracks fast and does not filter. Every detected frame edge resets the frame position counter at once, and every detected clock edge resets the divide-by-BIT_DIV bit phase. The block regenerates an 8.192 MHz bit enable, a frame strobe and a time-slot number. It also reports whether the reference has been steady for long enough to call it locked. The tracker keeps running whether or not the device is acting as timing master.

The lock state machine has three states:
- `ST_ACQ` waits for the first frame edge. That edge aligns the counter and moves the machine to `ST_TRACK`.
- `ST_TRACK` counts consecutive in-tolerance frame edges. After LOCK_FRAMES of them it moves to `ST_LOCK`.
- `ST_LOCK` drives the lock flag. A frame edge outside tolerance, or a missing frame, sends `ST_LOCK` back to `ST_TRACK` and sends `ST_TRACK` back to its own start with the count cleared.
- A change of the select input forces `ST_ACQ` from any state.

Top module: `fct_tracker`

## Requirements
- R1: While reset is asserted, `locked_o` is 0 and `slot_o` is 0.
- R2: A rising edge of the selected reference clock first sampled at system clock edge k makes `bit_ce_o` high in the cycle after edge k+1. `bit_ce_o` then pulses once every BIT_DIV cycles.
- R3: A rise of the selected frame pulse first sampled at edge k resets the frame position, so that `frame_stb_o` is high in the cycle after edge k+1+FRAME_LEN and every FRAME_LEN cycles after that. When the reference is already aligned, `frame_stb_o` is also high in the cycle after edge k+1.
- R4: `slot_o` equals the frame position divided by SLOT_CYC. It is 0 in the strobe cycle and 1 exactly SLOT_CYC cycles later.
- R5: Every frame edge realigns the timebase, including a frame edge far from the expected position. The strobe therefore follows the new reference from the next frame on.
- R6: `locked_o` rises only after LOCK_FRAMES consecutive in-tolerance frame edges that follow the aligning edge. It is still 0 after one edge fewer.
- R7: A frame edge landing within ±TOL system clocks of its expected position keeps `locked_o` high.
- R8: A frame edge more than TOL clocks from its expected position clears `locked_o`.
- R9: If no frame edge arrives within FRAME_LEN+TOL cycles of the previous one, `locked_o` clears.
- R10: A change of `ref_sel_i` clears `locked_o` in the next cycle. Acquisition then restarts on the newly selected pair, including its bit phase.
- R11: Frame pulses on pairs that are not selected have no effect on `locked_o` or on the strobe timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (131.072 MHz nominal) |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | N_REF | Reference clocks, one per input pair, asynchronous |
| ref_frm_i | input | N_REF | Reference frame pulses, one per input pair, asynchronous |
| ref_sel_i | input | $clog2(N_REF) | Index of the tracked pair |
| bit_ce_o | output | 1 | Regenerated bit-clock enable, one cycle in BIT_DIV |
| frame_stb_o | output | 1 | One-cycle frame strobe at frame position 0 |
| slot_o | output | $clog2(FRAME_LEN/SLOT_CYC) | Current time-slot number |
| locked_o | output | 1 | Lock indication |

## Verification
The bench builds the tracker with FRAME_LEN=64, SLOT_CYC=16, BIT_DIV=16, TOL=2, LOCK_FRAMES=4 and all six reference pairs. A 64-cycle frame lets one run cover acquisition, many frames of lock, late and early edges, a missing frame and a switch of reference. The run stays at a few thousand cycles, where the 16384-cycle default frame would need far more. Tolerance edges, slot boundaries and bit-phase offsets then fall on exact cycles that the bench computes from the reference timing it drives.

// File: rtl/fct_pkg.sv
package fct_pkg;
    typedef enum logic [1:0] {
        ST_ACQ   = 2'd0,
        ST_TRACK = 2'd1,
        ST_LOCK  = 2'd2
    } trk_state_t;
endpackage

// File: rtl/fct_edge_sync.sv
module fct_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise_o
);
    logic s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= din;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise_o = s2 & ~s3;

    // R2
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/fct_timebase.sv
module fct_timebase #(
    parameter int FRAME_LEN = 16384,
    parameter int BIT_DIV   = 16,
    parameter int SLOT_CYC  = 128,
    localparam int FW  = $clog2(FRAME_LEN),
    localparam int BW  = $clog2(BIT_DIV),
    localparam int SCW = $clog2(SLOT_CYC),
    localparam int SLW = FW - SCW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_rise_i,
    input  logic          frm_rise_i,
    output logic          bit_ce_o,
    output logic          frame_stb_o,
    output logic [SLW-1:0] slot_o,
    output logic [FW-1:0] fpos_o
);
    localparam logic [FW-1:0] F_LAST = FW'(FRAME_LEN - 1);
    localparam logic [BW-1:0] B_LAST = BW'(BIT_DIV - 1);

    logic [FW-1:0] fcnt;
    logic [BW-1:0] bcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fcnt <= '0;
        end else if (frm_rise_i) begin
            fcnt <= FW'(1);
        end else if (fcnt == F_LAST) begin
            fcnt <= '0;
        end else begin
            fcnt <= fcnt + FW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt <= '0;
        end else if (clk_rise_i) begin
            bcnt <= BW'(1);
        end else if (bcnt == B_LAST) begin
            bcnt <= '0;
        end else begin
            bcnt <= bcnt + BW'(1);
        end
    end

    assign bit_ce_o    = (bcnt == '0);
    assign frame_stb_o = (fcnt == '0);
    assign slot_o      = fcnt[FW-1:SCW];
    assign fpos_o      = fcnt;

    // R3
    frame_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_rise_i |=> (fpos_o == FW'(1)) && !frame_stb_o);

    // R2
    bit_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_rise_i |=> !bit_ce_o);

    // R4
    slot_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frm_rise_i && frame_stb_o) |=> (slot_o == '0));
endmodule

// File: rtl/fct_lock_fsm.sv
module fct_lock_fsm
    import fct_pkg::*;
#(
    parameter int FRAME_LEN   = 16384,
    parameter int TOL         = 2,
    parameter int LOCK_FRAMES = 4,
    localparam int FW = $clog2(FRAME_LEN),
    localparam int GW = $clog2(FRAME_LEN + TOL + 2),
    localparam int CW = $clog2(LOCK_FRAMES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frm_rise_i,
    input  logic [FW-1:0] fpos_i,
    input  logic          sel_chg_i,
    output logic          locked_o
);
    localparam logic [GW-1:0] GAP_LIM  = GW'(FRAME_LEN + TOL);
    localparam logic [CW-1:0] GOOD_END = CW'(LOCK_FRAMES - 1);

    trk_state_t    state, state_n;
    logic [CW-1:0] gcnt, gcnt_n;
    logic [GW-1:0] gap;
    logic          in_tol, miss, bad_edge;

    assign in_tol   = (int'(fpos_i) <= TOL) || (int'(fpos_i) >= FRAME_LEN - TOL);
    assign miss     = (state != ST_ACQ) && !frm_rise_i && (gap == GAP_LIM - GW'(1));
    assign bad_edge = frm_rise_i && !in_tol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap <= '0;
        end else if (frm_rise_i) begin
            gap <= '0;
        end else if (gap != GAP_LIM) begin
            gap <= gap + GW'(1);
        end
    end

    always_comb begin
        state_n = state;
        gcnt_n  = gcnt;
        unique case (state)
            ST_ACQ: begin
                if (frm_rise_i) begin
                    state_n = ST_TRACK;
                    gcnt_n  = '0;
                end
            end
            ST_TRACK: begin
                if (miss || bad_edge) begin
                    gcnt_n = '0;
                end else if (frm_rise_i) begin
                    if (gcnt == GOOD_END) begin
                        state_n = ST_LOCK;
                        gcnt_n  = '0;
                    end else begin
                        gcnt_n = gcnt + CW'(1);
                    end
                end
            end
            ST_LOCK: begin
                if (miss || bad_edge) begin
                    state_n = ST_TRACK;
                    gcnt_n  = '0;
                end
            end
            default: begin
                state_n = ST_ACQ;
                gcnt_n  = '0;
            end
        endcase
        if (sel_chg_i) begin
            state_n = ST_ACQ;
            gcnt_n  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_ACQ;
            gcnt  <= '0;
        end else begin
            state <= state_n;
            gcnt  <= gcnt_n;
        end
    end

    always_comb begin
        locked_o = (state == ST_LOCK);
    end

    // R6
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(frm_rise_i));

    // R8
    bad_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_edge |=> !locked_o);

    // R9
    miss_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> !locked_o);

    // R10
    sel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_chg_i |=> !locked_o);
endmodule

// File: rtl/fct_tracker.sv
module fct_tracker #(
    parameter int N_REF       = 6,
    parameter int FRAME_LEN   = 16384,
    parameter int BIT_DIV     = 16,
    parameter int SLOT_CYC    = 128,
    parameter int TOL         = 2,
    parameter int LOCK_FRAMES = 4,
    localparam int SELW = $clog2(N_REF),
    localparam int FW   = $clog2(FRAME_LEN),
    localparam int SLW  = FW - $clog2(SLOT_CYC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_REF-1:0] ref_clk_i,
    input  logic [N_REF-1:0] ref_frm_i,
    input  logic [SELW-1:0] ref_sel_i,
    output logic            bit_ce_o,
    output logic            frame_stb_o,
    output logic [SLW-1:0]  slot_o,
    output logic            locked_o
);
    logic [SELW-1:0] sel_q;
    logic            sel_chg;
    logic            clk_mux, frm_mux;
    logic            clk_rise, frm_rise;
    logic [FW-1:0]   fpos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= ref_sel_i;
        end
    end

    assign sel_chg = (ref_sel_i != sel_q);

    always_comb begin
        clk_mux = 1'b0;
        frm_mux = 1'b0;
        for (int i = 0; i < N_REF; i++) begin
            if (sel_q == SELW'(i)) begin
                clk_mux = ref_clk_i[i];
                frm_mux = ref_frm_i[i];
            end
        end
    end

    fct_edge_sync u_clk_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (clk_mux),
        .rise_o (clk_rise)
    );

    fct_edge_sync u_frm_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (frm_mux),
        .rise_o (frm_rise)
    );

    fct_timebase #(
        .FRAME_LEN (FRAME_LEN),
        .BIT_DIV   (BIT_DIV),
        .SLOT_CYC  (SLOT_CYC)
    ) u_timebase (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_rise_i  (clk_rise),
        .frm_rise_i  (frm_rise),
        .bit_ce_o    (bit_ce_o),
        .frame_stb_o (frame_stb_o),
        .slot_o      (slot_o),
        .fpos_o      (fpos)
    );

    fct_lock_fsm #(
        .FRAME_LEN   (FRAME_LEN),
        .TOL         (TOL),
        .LOCK_FRAMES (LOCK_FRAMES)
    ) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_rise_i (frm_rise),
        .fpos_i     (fpos),
        .sel_chg_i  (sel_chg),
        .locked_o   (locked_o)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> !locked_o && (slot_o == '0));
endmodule

// File: tb/fct_tracker_tb.sv
`timescale 1ns/1ps
module fct_tracker_tb_top;
    localparam int N_REF = 6;
    localparam int FL    = 64;
    localparam int BD    = 16;
    localparam int SC    = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] ref_clk = '0;
    logic [5:0] ref_frm = '0;
    logic [2:0] ref_sel = '0;
    logic       bit_ce, frame_stb, locked;
    logic [1:0] slot;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int ck_lane = 0;
    int ck_off = 5;
    bit ck_on = 1'b0;

    always #10 clk = ~clk;

    fct_tracker #(
        .N_REF(N_REF), .FRAME_LEN(FL), .BIT_DIV(BD), .SLOT_CYC(SC),
        .TOL(2), .LOCK_FRAMES(4)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .ref_frm_i(ref_frm),
        .ref_sel_i(ref_sel), .bit_ce_o(bit_ce), .frame_stb_o(frame_stb),
        .slot_o(slot), .locked_o(locked)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        ref_clk <= '0;
        if (ck_on) ref_clk[ck_lane] <= (((cyc + 1600 - ck_off) % BD) < BD / 2);
    end

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc == 30000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: cycle limit reached, got %0d expected below 30000", cyc);
            report();
        end
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // one frame on a lane; next pulse starts 'period' cycles later
    task automatic frame(int lane, int period, bit chk);
        ref_frm[lane] = 1'b1;
        tick(1);
        ref_frm[lane] = 1'b0;
        tick(1);
        if (chk) begin
            check("R3 strobe two cycles after pulse", int'(frame_stb), 1);
            check("R4 slot zero at strobe", int'(slot), 0);
        end
        tick(SC);
        if (chk) check("R4 slot one after SLOT_CYC", int'(slot), 1);
        tick(period - SC - 2);
    endtask

    task automatic check_bits(string req, int n);
        int errs = 0;
        int first_act = 0;
        int first_exp = 0;
        for (int i = 0; i < n; i++) begin
            int exp = (((cyc + 1600 - ck_off - 2) % BD) == 0) ? 1 : 0;
            if (int'(bit_ce) != exp && errs == 0) begin
                first_act = int'(bit_ce);
                first_exp = exp;
            end
            if (int'(bit_ce) != exp) errs++;
            tick(1);
        end
        if (errs != 0) check(req, first_act, first_exp);
        else check(req, 0, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        tick(5);
        check("R1 locked in reset", int'(locked), 0);
        check("R1 slot in reset", int'(slot), 0);
        ck_on = 1'b1;
        rst_n = 1'b1;
        tick(30);
    endtask

    task automatic t_bits;
        check_bits("R2 bit enable phase", 2 * BD);
    endtask

    task automatic t_lock;
        frame(0, FL, 1'b0);
        for (int i = 0; i < 3; i++) frame(0, FL, 1'b1);
        check("R6 not locked after three", int'(locked), 0);
        frame(0, FL, 1'b1);
        check("R6 locked after four", int'(locked), 1);
    endtask

    task automatic t_tolerance;
        frame(0, FL + 2, 1'b1);
        frame(0, FL, 1'b0);
        check("R7 late by TOL keeps lock", int'(locked), 1);
        frame(0, FL, 1'b1);
        check("R5 realigned after late edge", int'(locked), 1);
        frame(0, FL - 5, 1'b1);
        frame(0, FL, 1'b0);
        check("R8 early by five drops lock", int'(locked), 0);
        frame(0, FL, 1'b1);
    endtask

    task automatic t_ignore;
        for (int i = 0; i < 5; i++) frame(0, FL, 1'b0);
        check("R6 relocked", int'(locked), 1);
        ref_frm[0] = 1'b1;
        tick(1);
        ref_frm[0] = 1'b0;
        tick(19);
        ref_frm[3] = 1'b1;
        tick(1);
        ref_frm[3] = 1'b0;
        tick(FL - 21);
        check("R11 unselected pulse ignored", int'(locked), 1);
        frame(0, FL, 1'b1);
        check("R11 lock kept", int'(locked), 1);
    endtask

    task automatic t_miss;
        tick(FL + 16);
        check("R9 missing frame drops lock", int'(locked), 0);
    endtask

    task automatic t_select;
        for (int i = 0; i < 5; i++) frame(0, FL, 1'b0);
        check("R10 locked before switch", int'(locked), 1);
        ref_sel = 3'd1;
        ck_lane = 1;
        ck_off = 11;
        tick(1);
        check("R10 lock cleared on select change", int'(locked), 0);
        tick(7);
        frame(1, FL, 1'b0);
        for (int i = 0; i < 4; i++) frame(1, FL, 1'b1);
        check("R10 reacquired on new pair", int'(locked), 1);
        check_bits("R10 bit phase follows new pair", 2 * BD);
    endtask

    initial begin
        t_reset();
        t_bits();
        t_lock();
        t_tolerance();
        t_ignore();
        t_miss();
        t_select();
        report();
    end
endmodule